// File: doc/BRIEF.md
# Precision Time Counter with Command Control

This block keeps a network-synchronisation clock made of a 32-bit seconds count and a 31-bit subsecond count. Software programs it through a small word-addressed register port. It writes the offset, addend and target registers first. Then it issues one-shot commands through a control word. Each command bit stays set while the command waits to be carried out, and the hardware clears it once the command has run.

The clock can advance in two ways. In coarse mode it adds a fixed amount on every enabled cycle. In fine mode a 32-bit accumulator adds a programmable addend on every enabled cycle, and each carry out of the accumulator advances the subseconds by one. Software can load the time outright or shift it by a signed offset. A one-shot comparison against a target time raises a sticky interrupt flag.

Top module: `ptp_time_ctrl`

## Requirements
- R1: After reset every register reads zero, the time outputs are zero and `irq_o` is low. Register map by word address: 0 control, 1 status, 2 addend, 3 offset seconds, 4 offset subseconds (bit 31 sign, bits 30:0 magnitude), 5 target seconds, 6 target subseconds. Control bits: 0 run enable, 1 fine mode, 2 load time, 3 shift time, 4 arm compare, 5 addend transfer. Control bits 31:6 always read zero.
- R2: The time advances only while control bit 0 and `ts_en_i` are both high. In coarse mode (bit 1 = 0) the subseconds grow by `COARSE_INC` per clock. Otherwise the time holds.
- R3: Once accepted, a load-time command copies offset seconds and offset subseconds (sign ignored) into the time on the clock edge after the accepting edge.
- R4: The subsecond count wraps at 2^31, and the wrap adds one to the seconds.
- R5: Once accepted, a shift-time command acts on the clock edge after the accepting edge. With sign 0 it adds the offset to the time, and a subsecond carry adds one more second. With sign 1 it subtracts the offset, and a subsecond borrow removes one more second.
- R6: A write of bit 2 or bit 3 is ignored while either of them reads 1. A write of bit 3 together with bit 2 starts only the load.
- R7: An accepted command bit (2, 3 or 5) reads 1 for exactly one cycle and then reads 0.
- R8: Bit 5 copies the addend register into the active addend. A write of bit 5 while it reads 1 is ignored. Writing the addend register alone does not change the rate.
- R9: In fine mode the subseconds rise by one for each carry out of a 32-bit accumulator that adds the active addend every enabled cycle.
- R10: While bit 4 is set and the time is strictly greater than the target (seconds compared first, then subseconds), the next edge sets the flag and clears bit 4. Equal time, or bit 4 clear, leaves the flag low.
- R11: The flag drives `irq_o` and stays set until software writes 1 to status bit 0. Writing 0 there has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| ts_en_i | input | 1 | Time-stamp enable, gates advancing |
| irq_o | output | 1 | Target-time interrupt flag |
| time_sec_o | output | SEC_W | Current seconds |
| time_sub_o | output | SUB_W | Current subseconds |

## Verification
The hardest case to reach is a command write that lands on the exact edge where an earlier command is still pending. Only that edge shows whether the refusal rule works, and an accepted command clears itself one cycle later. The bench issues two control writes on back-to-back cycles with no idle cycle between them. It checks the refused write two ways: the time moves by only one offset, and the addend-transfer bit has cleared when read. The fine-mode rate is checked with addends that are exact powers of two. Their carries then fall at a fixed count per window, whatever the starting phase of the accumulator.

// File: rtl/ptp_time_pkg.sv
package ptp_time_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 3;

  // control word bit positions
  localparam int unsigned CB_RUN   = 0;
  localparam int unsigned CB_FINE  = 1;
  localparam int unsigned CB_LOAD  = 2;
  localparam int unsigned CB_SHIFT = 3;
  localparam int unsigned CB_ARM   = 4;
  localparam int unsigned CB_XFER  = 5;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL    = 3'd0,
    RA_STATUS  = 3'd1,
    RA_ADDEND  = 3'd2,
    RA_OFS_SEC = 3'd3,
    RA_OFS_SUB = 3'd4,
    RA_TGT_SEC = 3'd5,
    RA_TGT_SUB = 3'd6,
    RA_SPARE   = 3'd7
  } ptp_reg_e;
endpackage

// File: rtl/ptp_rate_gen.sv
module ptp_rate_gen #(
  parameter int unsigned ACC_W      = 32,
  parameter int unsigned SUB_W      = 31,
  parameter int unsigned COARSE_INC = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             fine_i,
  input  logic             load_i,
  input  logic [ACC_W-1:0] addend_i,
  output logic [SUB_W-1:0] step_o
);
  logic [ACC_W-1:0] active_q, acc_q, acc_d;
  logic             carry;
  logic             acc_en;

  always_comb begin
    {carry, acc_d} = {1'b0, acc_q} + {1'b0, active_q};
    acc_en         = run_i & fine_i;
    if (!run_i)      step_o = '0;
    else if (fine_i) step_o = SUB_W'(carry);
    else             step_o = SUB_W'(COARSE_INC);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      acc_q    <= '0;
    end else begin
      if (load_i) active_q <= addend_i;
      if (acc_en) acc_q    <= acc_d;
    end
  end
endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core #(
  parameter int unsigned SEC_W = 32,
  parameter int unsigned SUB_W = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SUB_W-1:0] step_i,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic             neg_i,
  input  logic [SEC_W-1:0] ofs_sec_i,
  input  logic [SUB_W-1:0] ofs_sub_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [SUB_W-1:0] sub_o
);
  logic [SEC_W-1:0] sec_q, sec_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic [SUB_W:0]   tick_sum, ofs_sum;
  logic             time_en;

  always_comb begin
    tick_sum = {1'b0, sub_q} + {1'b0, step_i};
    if (neg_i) ofs_sum = {1'b0, sub_q} - {1'b0, ofs_sub_i};
    else       ofs_sum = {1'b0, sub_q} + {1'b0, ofs_sub_i};
    sec_d = sec_q;
    sub_d = sub_q;
    if (load_i) begin
      sec_d = ofs_sec_i;
      sub_d = ofs_sub_i;
    end else if (shift_i) begin
      sub_d = ofs_sum[SUB_W-1:0];
      if (neg_i) sec_d = sec_q - ofs_sec_i - SEC_W'(ofs_sum[SUB_W]);
      else       sec_d = sec_q + ofs_sec_i + SEC_W'(ofs_sum[SUB_W]);
    end else begin
      sub_d = tick_sum[SUB_W-1:0];
      sec_d = sec_q + SEC_W'(tick_sum[SUB_W]);
    end
    time_en = load_i | shift_i | (|step_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      sub_q <= '0;
    end else if (time_en) begin
      sec_q <= sec_d;
      sub_q <= sub_d;
    end
  end

  assign sec_o = sec_q;
  assign sub_o = sub_q;
endmodule

// File: rtl/ptp_target_cmp.sv
module ptp_target_cmp #(
  parameter int unsigned SEC_W = 32,
  parameter int unsigned SUB_W = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [SUB_W-1:0] sub_i,
  input  logic [SEC_W-1:0] tgt_sec_i,
  input  logic [SUB_W-1:0] tgt_sub_i,
  input  logic             armed_i,
  input  logic             clr_i,
  output logic             fire_o,
  output logic             flag_o
);
  logic past_tgt;
  logic flag_q, flag_d, flag_en;

  always_comb begin
    past_tgt = (sec_i > tgt_sec_i) || ((sec_i == tgt_sec_i) && (sub_i > tgt_sub_i));
    fire_o   = armed_i & past_tgt;
    flag_en  = fire_o | clr_i;
    flag_d   = fire_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ptp_time_ctrl.sv
module ptp_time_ctrl
  import ptp_time_pkg::*;
#(
  parameter int unsigned ACC_W      = 32,
  parameter int unsigned SEC_W      = 32,
  parameter int unsigned SUB_W      = 31,
  parameter int unsigned COARSE_INC = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              ts_en_i,
  output logic              irq_o,
  output logic [SEC_W-1:0]  time_sec_o,
  output logic [SUB_W-1:0]  time_sub_o
);
  localparam int unsigned SIGN_BIT = DATA_W - 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // write decode
  logic wr_ctrl, wr_addend, wr_ofs_sec, wr_ofs_sub, wr_tgt_sec, wr_tgt_sub, sts_clr;
  always_comb begin
    wr_ctrl    = reg_wr_i && (reg_addr_i == RA_CTRL);
    wr_addend  = reg_wr_i && (reg_addr_i == RA_ADDEND);
    wr_ofs_sec = reg_wr_i && (reg_addr_i == RA_OFS_SEC);
    wr_ofs_sub = reg_wr_i && (reg_addr_i == RA_OFS_SUB);
    wr_tgt_sec = reg_wr_i && (reg_addr_i == RA_TGT_SEC);
    wr_tgt_sub = reg_wr_i && (reg_addr_i == RA_TGT_SUB);
    sts_clr    = reg_wr_i && (reg_addr_i == RA_STATUS) && reg_wdata_i[0];
  end

  // data registers
  logic [ACC_W-1:0] addend_q;
  logic [SEC_W-1:0] ofs_sec_q, tgt_sec_q;
  logic [SUB_W-1:0] ofs_sub_q, tgt_sub_q;
  logic             ofs_neg_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      addend_q  <= '0;
      ofs_sec_q <= '0;
      ofs_sub_q <= '0;
      ofs_neg_q <= 1'b0;
      tgt_sec_q <= '0;
      tgt_sub_q <= '0;
    end else begin
      if (wr_addend)  addend_q  <= reg_wdata_i[ACC_W-1:0];
      if (wr_ofs_sec) ofs_sec_q <= reg_wdata_i[SEC_W-1:0];
      if (wr_ofs_sub) begin
        ofs_sub_q <= reg_wdata_i[SUB_W-1:0];
        ofs_neg_q <= reg_wdata_i[SIGN_BIT];
      end
      if (wr_tgt_sec) tgt_sec_q <= reg_wdata_i[SEC_W-1:0];
      if (wr_tgt_sub) tgt_sub_q <= reg_wdata_i[SUB_W-1:0];
    end
  end

  // control word: next state
  logic run_en_q, fine_q, load_q, shift_q, arm_q, xfer_q;
  logic run_en_d, fine_d, load_d, shift_d, arm_d, xfer_d;
  logic fire, cmd_busy;

  always_comb begin
    cmd_busy = load_q | shift_q;
    run_en_d = wr_ctrl ? reg_wdata_i[CB_RUN]  : run_en_q;
    fine_d   = wr_ctrl ? reg_wdata_i[CB_FINE] : fine_q;
    load_d   = wr_ctrl & reg_wdata_i[CB_LOAD] & ~cmd_busy;
    shift_d  = wr_ctrl & reg_wdata_i[CB_SHIFT] & ~reg_wdata_i[CB_LOAD] & ~cmd_busy;
    xfer_d   = wr_ctrl & reg_wdata_i[CB_XFER] & ~xfer_q;
    if (wr_ctrl)   arm_d = reg_wdata_i[CB_ARM];
    else if (fire) arm_d = 1'b0;
    else           arm_d = arm_q;
  end

  // control word: registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      run_en_q <= 1'b0;
      fine_q   <= 1'b0;
      load_q   <= 1'b0;
      shift_q  <= 1'b0;
      arm_q    <= 1'b0;
      xfer_q   <= 1'b0;
    end else begin
      run_en_q <= run_en_d;
      fine_q   <= fine_d;
      load_q   <= load_d;
      shift_q  <= shift_d;
      arm_q    <= arm_d;
      xfer_q   <= xfer_d;
    end
  end

  logic             running;
  logic [SUB_W-1:0] step;
  logic             flag;

  assign running = run_en_q & ts_en_i;

  ptp_rate_gen #(
    .ACC_W(ACC_W), .SUB_W(SUB_W), .COARSE_INC(COARSE_INC)
  ) u_rate (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .run_i    (running),
    .fine_i   (fine_q),
    .load_i   (xfer_q),
    .addend_i (addend_q),
    .step_o   (step)
  );

  ptp_time_core #(
    .SEC_W(SEC_W), .SUB_W(SUB_W)
  ) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .step_i    (step),
    .load_i    (load_q),
    .shift_i   (shift_q),
    .neg_i     (ofs_neg_q),
    .ofs_sec_i (ofs_sec_q),
    .ofs_sub_i (ofs_sub_q),
    .sec_o     (time_sec_o),
    .sub_o     (time_sub_o)
  );

  ptp_target_cmp #(
    .SEC_W(SEC_W), .SUB_W(SUB_W)
  ) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .sec_i     (time_sec_o),
    .sub_i     (time_sub_o),
    .tgt_sec_i (tgt_sec_q),
    .tgt_sub_i (tgt_sub_q),
    .armed_i   (arm_q),
    .clr_i     (sts_clr),
    .fire_o    (fire),
    .flag_o    (flag)
  );

  assign irq_o = flag;

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      RA_CTRL: begin
        reg_rdata_o[CB_RUN]   = run_en_q;
        reg_rdata_o[CB_FINE]  = fine_q;
        reg_rdata_o[CB_LOAD]  = load_q;
        reg_rdata_o[CB_SHIFT] = shift_q;
        reg_rdata_o[CB_ARM]   = arm_q;
        reg_rdata_o[CB_XFER]  = xfer_q;
      end
      RA_STATUS:  reg_rdata_o[0]          = flag;
      RA_ADDEND:  reg_rdata_o[ACC_W-1:0]  = addend_q;
      RA_OFS_SEC: reg_rdata_o[SEC_W-1:0]  = ofs_sec_q;
      RA_OFS_SUB: begin
        reg_rdata_o[SUB_W-1:0] = ofs_sub_q;
        reg_rdata_o[SIGN_BIT]  = ofs_neg_q;
      end
      RA_TGT_SEC: reg_rdata_o[SEC_W-1:0]  = tgt_sec_q;
      RA_TGT_SUB: reg_rdata_o[SUB_W-1:0]  = tgt_sub_q;
      default:    reg_rdata_o             = '0;
    endcase
  end
endmodule

// File: rtl/ptp_time_ctrl_chk.sv
module ptp_time_ctrl_chk #(
  parameter int unsigned SEC_W      = 32,
  parameter int unsigned SUB_W      = 31,
  parameter int unsigned COARSE_INC = 20
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             running,
  input logic             fine,
  input logic             load_p,
  input logic             shift_p,
  input logic             wr_ctrl,
  input logic             arm,
  input logic             irq,
  input logic             sts_clr,
  input logic [SEC_W-1:0] sec,
  input logic [SUB_W-1:0] sub,
  input logic [SEC_W-1:0] ofs_sec,
  input logic [SUB_W-1:0] ofs_sub
);
  logic [SUB_W:0] coarse_nxt;
  assign coarse_nxt = {1'b0, sub} + (SUB_W+1)'(COARSE_INC);

  AST_TIME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!running && !load_p && !shift_p) |=> ($stable(sec) && $stable(sub))); // R2

  AST_COARSE_STEP: assert property (@(posedge clk_i) disable iff (!rst_n)
    (running && !fine && !load_p && !shift_p && !coarse_nxt[SUB_W])
      |=> (sub == $past(coarse_nxt[SUB_W-1:0]))); // R2

  AST_LOAD_TAKES_OFS: assert property (@(posedge clk_i) disable iff (!rst_n)
    load_p |=> ((sec == $past(ofs_sec)) && (sub == $past(ofs_sub)))); // R3

  AST_NO_CMD_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(load_p && shift_p)); // R6

  AST_ARM_DROPS: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($rose(irq) && !$past(wr_ctrl)) |-> !arm); // R10

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    (irq && !sts_clr) |=> irq); // R11
endmodule

bind ptp_time_ctrl ptp_time_ctrl_chk #(
  .SEC_W(SEC_W), .SUB_W(SUB_W), .COARSE_INC(COARSE_INC)
) u_chk (
  .clk_i   (clk_i),
  .rst_n   (rst_n),
  .running (running),
  .fine    (fine_q),
  .load_p  (load_q),
  .shift_p (shift_q),
  .wr_ctrl (wr_ctrl),
  .arm     (arm_q),
  .irq     (irq_o),
  .sts_clr (sts_clr),
  .sec     (time_sec_o),
  .sub     (time_sub_o),
  .ofs_sec (ofs_sec_q),
  .ofs_sub (ofs_sub_q)
);

// File: tb/ptp_time_ctrl_bench.sv
`timescale 1ns/1ps
module ptp_time_ctrl_bench;
  localparam int unsigned INC = 20;
  localparam logic [31:0] WRAP = 32'h8000_0000;

  logic        clk, rst_n, wr, ts_en, irq;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata, sec;
  logic [30:0] sub;
  logic [31:0] mode;
  int          n_run, n_fail;
  bit          done;

  ptp_time_ctrl #(.COARSE_INC(INC)) u_ptp_time_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ts_en_i(ts_en),
    .irq_o(irq), .time_sec_o(sec), .time_sub_o(sub)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic chk_time(input string req, input logic [31:0] es, input logic [31:0] eu);
    chk({req, " sec"}, sec, es);
    chk({req, " sub"}, {1'b0, sub}, eu);
  endtask

  task automatic run(input int k);
    ts_en = 1'b1;
    repeat (k) @(negedge clk);
    ts_en = 1'b0;
  endtask

  task automatic set_time(input logic [31:0] s, input logic [31:0] u);
    wr_reg(3'd3, s);
    wr_reg(3'd4, u);
    wr_reg(3'd0, mode | 32'h4);
    @(negedge clk);
  endtask

  task automatic shift_time(input logic [31:0] s, input logic neg, input logic [30:0] m);
    wr_reg(3'd3, s);
    wr_reg(3'd4, {neg, m});
    wr_reg(3'd0, mode | 32'h8);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk_time("R1 reset time", 32'd0, 32'd0);
    chk("R1 reset irq", {31'd0, irq}, 32'd0);
    for (int a = 0; a < 8; a++) rd_chk("R1 reset register", a[2:0], 32'd0);
    wr_reg(3'd0, 32'hFFFF_FFC3);
    rd_chk("R1 reserved bits", 3'd0, 32'h3);
    mode = 32'h1;
    wr_reg(3'd0, mode);
  endtask

  task automatic t_coarse();
    set_time(32'd5, 32'd100);
    chk_time("R3 load", 32'd5, 32'd100);
    run(10);
    chk_time("R2 coarse advance", 32'd5, 32'd100 + 10 * INC);
    repeat (3) @(negedge clk);
    chk_time("R2 hold without ts_en", 32'd5, 32'd100 + 10 * INC);
  endtask

  task automatic t_wrap();
    set_time(32'd7, WRAP - INC);
    run(1);
    chk_time("R4 exact wrap", 32'd8, 32'd0);
    set_time(32'd7, WRAP - 25);
    run(2);
    chk_time("R4 wrap with remainder", 32'd8, 32'd15);
  endtask

  task automatic t_shift();
    set_time(32'd8, WRAP - 3);
    shift_time(32'd2, 1'b0, 31'd5);
    chk_time("R5 add with carry", 32'd11, 32'd2);
    set_time(32'd10, 32'd3);
    shift_time(32'd1, 1'b1, 31'd5);
    chk_time("R5 subtract with borrow", 32'd8, WRAP - 2);
    set_time(32'd10, 32'd100);
    shift_time(32'd1, 1'b1, 31'd40);
    chk_time("R5 subtract plain", 32'd9, 32'd60);
  endtask

  task automatic t_refuse();
    set_time(32'd0, 32'd0);
    wr_reg(3'd3, 32'd0);
    wr_reg(3'd4, 32'd10);
    wr_reg(3'd0, mode | 32'h8);
    wr_reg(3'd0, mode | 32'h8);
    @(negedge clk);
    chk_time("R6 back-to-back shift refused", 32'd0, 32'd10);
    wr_reg(3'd3, 32'd50);
    wr_reg(3'd4, 32'd7);
    wr_reg(3'd0, mode | 32'h4);
    wr_reg(3'd0, mode | 32'h8);
    @(negedge clk);
    chk_time("R6 shift refused during load", 32'd50, 32'd7);
    wr_reg(3'd0, mode | 32'hC);
    @(negedge clk);
    chk_time("R6 load wins over shift", 32'd50, 32'd7);
  endtask

  task automatic t_selfclear();
    wr_reg(3'd4, 32'd0);
    wr_reg(3'd0, mode | 32'h8);
    rd_chk("R7 shift bit pending", 3'd0, mode | 32'h8);
    @(negedge clk);
    rd_chk("R7 shift bit cleared", 3'd0, mode);
    wr_reg(3'd0, mode | 32'h4);
    rd_chk("R7 load bit pending", 3'd0, mode | 32'h4);
    @(negedge clk);
    rd_chk("R7 load bit cleared", 3'd0, mode);
  endtask

  task automatic t_fine();
    wr_reg(3'd2, 32'h4000_0000);
    wr_reg(3'd0, mode | 32'h20);
    wr_reg(3'd0, mode | 32'h20);
    rd_chk("R8 repeated transfer refused", 3'd0, mode);
    mode = 32'h3;
    wr_reg(3'd0, mode);
    set_time(32'd0, 32'd0);
    run(8);
    chk_time("R9 fine quarter rate", 32'd0, 32'd2);
    wr_reg(3'd2, 32'h8000_0000);
    run(8);
    chk_time("R8 addend write alone", 32'd0, 32'd4);
    wr_reg(3'd0, mode | 32'h20);
    @(negedge clk);
    run(8);
    chk_time("R9 fine half rate", 32'd0, 32'd8);
    mode = 32'h1;
    wr_reg(3'd0, mode);
  endtask

  task automatic t_irq();
    wr_reg(3'd5, 32'd20);
    wr_reg(3'd6, 32'd50);
    set_time(32'd20, 32'd50);
    wr_reg(3'd0, mode | 32'h10);
    repeat (2) @(negedge clk);
    chk("R10 equal time no irq", {31'd0, irq}, 32'd0);
    rd_chk("R10 still armed", 3'd0, mode | 32'h10);
    run(1);
    @(negedge clk);
    chk("R10 irq after passing", {31'd0, irq}, 32'd1);
    rd_chk("R10 arm cleared", 3'd0, mode);
    repeat (3) @(negedge clk);
    chk("R11 flag held", {31'd0, irq}, 32'd1);
    wr_reg(3'd1, 32'd0);
    chk("R11 write zero keeps flag", {31'd0, irq}, 32'd1);
    wr_reg(3'd1, 32'd1);
    chk("R11 write one clears", {31'd0, irq}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R10 unarmed no irq", {31'd0, irq}, 32'd0);
    wr_reg(3'd6, 32'h7FFF_FF00);
    set_time(32'd21, 32'd0);
    wr_reg(3'd0, mode | 32'h10);
    @(negedge clk);
    chk("R10 seconds compared first", {31'd0, irq}, 32'd1);
    wr_reg(3'd1, 32'd1);
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    wr = 1'b0; addr = '0; wdata = '0; ts_en = 1'b0; mode = 32'h1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_coarse();
    t_wrap();
    t_shift();
    t_refuse();
    t_selfclear();
    t_fine();
    t_irq();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule